// File: doc/BRIEF.md
# Non-Blocking Load Tracker for an In-Order Pipeline

This block keeps an in-order pipeline issuing while loads wait on cache misses. The issue stage shows it one instruction per cycle: the two source registers, the destination register, whether the instruction is a load, and for a load the cache lookup result (hit or miss, line address, word offset, and hit data). The block decides in the same cycle whether the instruction may issue. A missing load does not block issue. It either opens one of a small set of miss entries and sends a line request, or joins an entry already waiting on the same line. Its destination register is then marked busy.

Returning lines are accepted by entry number. Each waiting load is written to the register file through a single write port, one per cycle, and its busy mark is cleared in that same cycle. Only instructions that touch a busy register are held. A load that hits the cache completes while misses are still outstanding. Loads may therefore finish out of program order. If a hit collides with a fill write-back, the hit waits in a one-deep holding register.

Top module: `ldsb_unit`

## Requirements
- R1: A load that hits, issues, and meets no fill write-back in that cycle is written in the same cycle (wb_valid=1, wb_rd=iss_rd, wb_data=iss_hit_data, wb_src=3), even while misses are outstanding. wb_src encodes 0 none, 1 fill, 2 holding register, 3 direct hit.
- R2: A missing load that matches no waiting entry issues without a stall. In that cycle it raises miss_req_valid with miss_req_line=iss_line and miss_req_id set to the lowest-numbered free entry.
- R3: Up to ENTRIES (4) different lines may be outstanding. A missing load to a new line while all entries are busy stalls until an entry is freed. An entry frees after its last waiting load is written back.
- R4: A missing load whose line equals that of an entry still waiting for its fill joins that entry. It raises no request and does not stall. The waiting loads of an entry are written back in the order in which they joined, each taking the word at its own offset (word i is fill_data[i*32 +: 32]).
- R5: An instruction whose iss_rs1 or iss_rs2 names a busy register stalls. Instructions that read no busy register keep issuing.
- R6: An instruction that writes a register (iss_rd_en=1 or any load) stalls while its destination register is busy.
- R7: A fill is written back starting the cycle after fill_valid. When several entries hold filled data, the lowest-numbered one goes first. The busy mark of a register clears in its write-back cycle, so a dependant issues in the next cycle.
- R8: Fills may return in any order relative to the requests, and write-backs follow fill order, not program order.
- R9: A fill write-back takes the port ahead of a hit. A hit that issues during a fill write-back is held, its register marked busy, and it is written (wb_src=2) in the next cycle without a fill write-back. A hit that arrives while the holding register is occupied stalls.
- R10: A missing load that matches a waiting entry whose TGTS (2) join slots are all used stalls.
- R11: After reset no register is busy, no entry is in use, and with no instruction presented there is no stall, no request and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iss_valid | input | 1 | Instruction presented at issue |
| iss_is_load | input | 1 | Instruction is a load |
| iss_rs1 | input | 5 | First source register |
| iss_rs2 | input | 5 | Second source register |
| iss_rd | input | 5 | Destination register |
| iss_rd_en | input | 1 | Non-load writes iss_rd |
| iss_hit | input | 1 | Load lookup hit |
| iss_line | input | 26 | Load line address |
| iss_word | input | 2 | Word offset within the line |
| iss_hit_data | input | 32 | Data of a hitting load |
| fill_valid | input | 1 | Line data returns |
| fill_id | input | 2 | Entry the fill belongs to |
| fill_data | input | 128 | Returned line, word i in bits i*32 upward |
| iss_stall | output | 1 | Presented instruction must be held |
| miss_req_valid | output | 1 | New line request |
| miss_req_id | output | 2 | Entry number of the request |
| miss_req_line | output | 26 | Line address requested |
| wb_valid | output | 1 | Register write this cycle |
| wb_rd | output | 5 | Register written |
| wb_data | output | 32 | Data written |
| wb_src | output | 2 | Source of the write (R1 encoding) |

## Verification
The hardest case to reach is a hit that issues in the very cycle a filled entry is draining. The hit must go to the holding register. A second hit must then stall on the occupied holding register, while a merged entry and other unfilled entries stay outstanding. Random stimulus reaches this by drawing lines from a pool of six addresses and registers from a small set. A stalled instruction is held at issue, and fills are returned at random to whichever entries are still waiting, so merges, full entries, write-back collisions and out-of-order fills arise often. A directed opening walks through merge, a full join slot, a full buffer and an out-of-order fill before the random phase.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;
    typedef enum logic [1:0] {
        WB_NONE = 2'd0,
        WB_FILL = 2'd1,
        WB_SKID = 2'd2,
        WB_HIT  = 2'd3
    } wb_src_e;
endpackage

// File: rtl/ldsb_scoreboard.sv
module ldsb_scoreboard #(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rs1,
    input  logic [RW-1:0] rs2,
    input  logic [RW-1:0] rd,
    input  logic          rd_chk,
    input  logic          set_en,
    input  logic [RW-1:0] set_rd,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_rd,
    output logic          hazard
);
    typedef struct packed {
        logic [NREG-1:0] busy;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        hazard = s_q.busy[rs1] || s_q.busy[rs2] || (rd_chk && s_q.busy[rd]);
        if (clr_en) s_d.busy[clr_rd] = 1'b0;
        if (set_en) s_d.busy[set_rd] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_SET_FREE_REG: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !s_q.busy[set_rd]);                           // R6
    AST_CLR_HELD_REG: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> s_q.busy[clr_rd]);                            // R7
    AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !s_q.busy[$past(clr_rd)]);                    // R7
endmodule

// File: rtl/ldsb_missbuf.sv
module ldsb_missbuf #(
    parameter int ENTRIES = 4,
    parameter int TGTS    = 2,
    parameter int LINE_W  = 26,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 4,
    parameter int NREG    = 32,
    localparam int RW     = $clog2(NREG),
    localparam int ID_W   = $clog2(ENTRIES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TS_W   = (TGTS > 1) ? $clog2(TGTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINE_W-1:0]       lk_line,
    output logic                    lk_match,
    output logic                    lk_full,
    output logic                    lk_free,
    output logic [ID_W-1:0]         lk_free_id,
    input  logic                    tk_en,
    input  logic [RW-1:0]           tk_rd,
    input  logic [OFF_W-1:0]        tk_word,
    input  logic                    fl_valid,
    input  logic [ID_W-1:0]         fl_id,
    input  logic [WORDS*DATA_W-1:0] fl_data,
    output logic                    dr_valid,
    output logic [RW-1:0]           dr_rd,
    output logic [DATA_W-1:0]       dr_data
);
    typedef struct packed {
        logic                              v;
        logic                              f;
        logic [LINE_W-1:0]                 line;
        logic [WORDS-1:0][DATA_W-1:0]      data;
        logic [TGTS-1:0]                   tv;
        logic [TGTS-1:0][RW-1:0]           trd;
        logic [TGTS-1:0][OFF_W-1:0]        twd;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] e;
    } st_t;

    st_t              s_q, s_d;
    logic [ID_W-1:0]  mid, de;
    logic [TS_W-1:0]  ms, dt;

    always_comb begin
        s_d        = s_q;
        lk_match   = 1'b0;
        mid        = '0;
        lk_free    = 1'b0;
        lk_free_id = '0;
        ms         = '0;
        dr_valid   = 1'b0;
        de         = '0;
        dt         = '0;

        for (int e = 0; e < ENTRIES; e++) begin
            if (s_q.e[e].v && !s_q.e[e].f && s_q.e[e].line == lk_line) begin
                lk_match = 1'b1;
                mid      = ID_W'(e);
            end
        end
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!s_q.e[e].v) begin
                lk_free    = 1'b1;
                lk_free_id = ID_W'(e);
            end
            if (s_q.e[e].v && s_q.e[e].f && |s_q.e[e].tv) begin
                dr_valid = 1'b1;
                de       = ID_W'(e);
            end
        end
        for (int t = TGTS - 1; t >= 0; t--) begin
            if (!s_q.e[mid].tv[t]) ms = TS_W'(t);
            if (s_q.e[de].tv[t])   dt = TS_W'(t);
        end
        lk_full = lk_match && (&s_q.e[mid].tv);
        dr_rd   = s_q.e[de].trd[dt];
        dr_data = s_q.e[de].data[s_q.e[de].twd[dt]];

        if (dr_valid) begin
            s_d.e[de].tv[dt] = 1'b0;
            if (s_d.e[de].tv == '0) s_d.e[de].v = 1'b0;
        end
        if (fl_valid) begin
            s_d.e[fl_id].f    = 1'b1;
            s_d.e[fl_id].data = fl_data;
        end
        if (tk_en) begin
            if (lk_match) begin
                s_d.e[mid].tv[ms]  = 1'b1;
                s_d.e[mid].trd[ms] = tk_rd;
                s_d.e[mid].twd[ms] = tk_word;
            end else begin
                s_d.e[lk_free_id].v      = 1'b1;
                s_d.e[lk_free_id].f      = 1'b0;
                s_d.e[lk_free_id].line   = lk_line;
                s_d.e[lk_free_id].tv     = TGTS'(1);
                s_d.e[lk_free_id].trd[0] = tk_rd;
                s_d.e[lk_free_id].twd[0] = tk_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_FILL_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> (s_q.e[fl_id].v && !s_q.e[fl_id].f));          // R7
    AST_TAKE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        tk_en |-> ((lk_match && !lk_full) || (!lk_match && lk_free))); // R3
    AST_LAST_DRAIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && $countones(s_q.e[de].tv) == 1) |=> !s_q.e[$past(de)].v); // R3
endmodule

// File: rtl/ldsb_unit.sv
module ldsb_unit
    import ldsb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int ENTRIES = 4,
    parameter int TGTS    = 2,
    parameter int LINE_W  = 26,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 4,
    localparam int RW     = $clog2(NREG),
    localparam int ID_W   = $clog2(ENTRIES),
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic                    iss_is_load,
    input  logic [RW-1:0]           iss_rs1,
    input  logic [RW-1:0]           iss_rs2,
    input  logic [RW-1:0]           iss_rd,
    input  logic                    iss_rd_en,
    input  logic                    iss_hit,
    input  logic [LINE_W-1:0]       iss_line,
    input  logic [OFF_W-1:0]        iss_word,
    input  logic [DATA_W-1:0]       iss_hit_data,
    input  logic                    fill_valid,
    input  logic [ID_W-1:0]         fill_id,
    input  logic [WORDS*DATA_W-1:0] fill_data,
    output logic                    iss_stall,
    output logic                    miss_req_valid,
    output logic [ID_W-1:0]         miss_req_id,
    output logic [LINE_W-1:0]       miss_req_line,
    output logic                    wb_valid,
    output logic [RW-1:0]           wb_rd,
    output logic [DATA_W-1:0]       wb_data,
    output logic [1:0]              wb_src
);
    typedef struct packed {
        logic              v;
        logic [RW-1:0]     rd;
        logic [DATA_W-1:0] data;
    } skid_t;

    typedef struct packed {
        skid_t sk;
    } st_t;

    st_t             s_q, s_d;
    logic            hazard, lk_match, lk_full, lk_free;
    logic [ID_W-1:0] lk_free_id;
    logic            dr_valid;
    logic [RW-1:0]   dr_rd;
    logic [DATA_W-1:0] dr_data;
    logic            fire, hit_fire, miss_fire;
    logic            set_en, clr_en;
    logic [RW-1:0]   set_rd, clr_rd;
    wb_src_e         src;

    always_comb begin
        s_d       = s_q;
        iss_stall = iss_valid && (hazard
                    || (iss_is_load &&  iss_hit && s_q.sk.v)
                    || (iss_is_load && !iss_hit && (lk_full || (!lk_match && !lk_free))));
        fire      = iss_valid && !iss_stall;
        hit_fire  = fire && iss_is_load &&  iss_hit;
        miss_fire = fire && iss_is_load && !iss_hit;

        miss_req_valid = miss_fire && !lk_match;
        miss_req_id    = lk_free_id;
        miss_req_line  = iss_line;

        src     = WB_NONE;
        wb_rd   = '0;
        wb_data = '0;
        if (dr_valid) begin
            src     = WB_FILL;
            wb_rd   = dr_rd;
            wb_data = dr_data;
        end else if (s_q.sk.v) begin
            src     = WB_SKID;
            wb_rd   = s_q.sk.rd;
            wb_data = s_q.sk.data;
        end else if (hit_fire) begin
            src     = WB_HIT;
            wb_rd   = iss_rd;
            wb_data = iss_hit_data;
        end
        wb_valid = (src != WB_NONE);
        wb_src   = src;

        if (s_q.sk.v && !dr_valid) s_d.sk.v = 1'b0;
        if (hit_fire && dr_valid) begin
            s_d.sk.v    = 1'b1;
            s_d.sk.rd   = iss_rd;
            s_d.sk.data = iss_hit_data;
        end

        set_en = miss_fire || (hit_fire && dr_valid);
        set_rd = iss_rd;
        clr_en = dr_valid || s_q.sk.v;
        clr_rd = dr_valid ? dr_rd : s_q.sk.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ldsb_scoreboard #(.NREG(NREG)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .rs1    (iss_rs1),
        .rs2    (iss_rs2),
        .rd     (iss_rd),
        .rd_chk (iss_rd_en || iss_is_load),
        .set_en (set_en),
        .set_rd (set_rd),
        .clr_en (clr_en),
        .clr_rd (clr_rd),
        .hazard (hazard)
    );

    ldsb_missbuf #(
        .ENTRIES (ENTRIES),
        .TGTS    (TGTS),
        .LINE_W  (LINE_W),
        .DATA_W  (DATA_W),
        .WORDS   (WORDS),
        .NREG    (NREG)
    ) u_mb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_line    (iss_line),
        .lk_match   (lk_match),
        .lk_full    (lk_full),
        .lk_free    (lk_free),
        .lk_free_id (lk_free_id),
        .tk_en      (miss_fire),
        .tk_rd      (iss_rd),
        .tk_word    (iss_word),
        .fl_valid   (fill_valid),
        .fl_id      (fill_id),
        .fl_data    (fill_data),
        .dr_valid   (dr_valid),
        .dr_rd      (dr_rd),
        .dr_data    (dr_data)
    );

    AST_SKID_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sk.v && !dr_valid) |=> !s_q.sk.v);                          // R9
    AST_MISS_REQ_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req_valid |-> (iss_valid && !iss_stall));                    // R2
    AST_HIT_WRITES_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_fire && !s_q.sk.v && !dr_valid) |-> (wb_valid && wb_rd == iss_rd)); // R1
    AST_FILL_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> (wb_src == 2'd1));                                   // R9
endmodule

// File: tb/sim_ldsb_unit.sv
`timescale 1ns/1ps
module sim_ldsb_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         iss_valid, iss_is_load, iss_rd_en, iss_hit;
    logic [4:0]   iss_rs1, iss_rs2, iss_rd;
    logic [25:0]  iss_line;
    logic [1:0]   iss_word;
    logic [31:0]  iss_hit_data;
    logic         fill_valid;
    logic [1:0]   fill_id;
    logic [127:0] fill_data;
    logic         iss_stall, miss_req_valid, wb_valid;
    logic [1:0]   miss_req_id, wb_src;
    logic [25:0]  miss_req_line;
    logic [4:0]   wb_rd;
    logic [31:0]  wb_data;

    ldsb_unit u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit          m_busy [32];
    bit          ev [4], ef [4];
    int          eline [4];
    logic [31:0] edat [4][4];
    bit          etv [4][2];
    int          etrd [4][2], etwd [4][2];
    bit          sk_v;
    int          sk_rd;
    logic [31:0] sk_d;
    bit          last_fire;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic eval();
        bit dv, hz, hzs, mt, full, fr, st, fire, hf, mf;
        int de, dt, me, ms, fid, src, xrd;
        logic [31:0] xd;
        string tg;
        dv = 0; de = 0; dt = 0;
        for (int e = 3; e >= 0; e--)
            if (ev[e] && ef[e] && (etv[e][0] || etv[e][1])) begin dv = 1; de = e; end
        if (dv) dt = etv[de][0] ? 0 : 1;
        hzs = m_busy[iss_rs1] || m_busy[iss_rs2];
        hz  = hzs || ((iss_rd_en || iss_is_load) && m_busy[iss_rd]);
        mt = 0; me = 0; fr = 0; fid = 0;
        for (int e = 0; e < 4; e++)
            if (ev[e] && !ef[e] && eline[e] == int'(iss_line)) begin mt = 1; me = e; end
        for (int e = 3; e >= 0; e--) if (!ev[e]) begin fr = 1; fid = e; end
        full = mt && etv[me][0] && etv[me][1];
        ms = etv[me][0] ? 1 : 0;
        st = 0; tg = "R5";
        if (iss_valid) begin
            if (hzs) begin st = 1; tg = "R5"; end
            else if (hz) begin st = 1; tg = "R6"; end
            else if (iss_is_load && iss_hit) begin st = sk_v; tg = sk_v ? "R9" : "R1"; end
            else if (iss_is_load) begin
                if (full) begin st = 1; tg = "R10"; end
                else if (!mt && !fr) begin st = 1; tg = "R3"; end
                else tg = mt ? "R4" : "R2";
            end
        end
        fire = iss_valid && !st;
        hf = fire && iss_is_load && iss_hit;
        mf = fire && iss_is_load && !iss_hit;
        chk(iss_stall == st, tg, "iss_stall", iss_stall, st);
        chk(miss_req_valid == (mf && !mt), mt ? "R4" : "R2", "miss_req_valid", miss_req_valid, mf && !mt);
        if (mf && !mt) begin
            chk(miss_req_id == 2'(fid), "R2", "miss_req_id", miss_req_id, fid);
            chk(miss_req_line == iss_line, "R2", "miss_req_line", miss_req_line, iss_line);
        end
        src = 0; xrd = 0; xd = '0;
        if (dv) begin src = 1; xrd = etrd[de][dt]; xd = edat[de][etwd[de][dt]]; end
        else if (sk_v) begin src = 2; xrd = sk_rd; xd = sk_d; end
        else if (hf) begin src = 3; xrd = int'(iss_rd); xd = iss_hit_data; end
        tg = (src == 1) ? "R7" : (src == 2) ? "R9" : (src == 3) ? "R1" : "R8";
        chk(wb_valid == (src != 0), tg, "wb_valid", wb_valid, src != 0);
        if (src != 0) begin
            chk(wb_src == 2'(src), tg, "wb_src", wb_src, src);
            chk(wb_rd == 5'(xrd), tg, "wb_rd", wb_rd, xrd);
            chk(wb_data == xd, (src == 1) ? "R4" : tg, "wb_data", wb_data, xd);
        end
        // advance model
        if (dv) begin
            etv[de][dt] = 0;
            if (!etv[de][0] && !etv[de][1]) ev[de] = 0;
            m_busy[xrd] = 0;
        end else if (sk_v) begin
            sk_v = 0; m_busy[sk_rd] = 0;
        end
        if (fill_valid) begin
            ef[fill_id] = 1;
            for (int w = 0; w < 4; w++) edat[fill_id][w] = fill_data[w*32 +: 32];
        end
        if (hf && dv) begin sk_v = 1; sk_rd = int'(iss_rd); sk_d = iss_hit_data; m_busy[iss_rd] = 1; end
        if (mf) begin
            m_busy[iss_rd] = 1;
            if (mt) begin etv[me][ms] = 1; etrd[me][ms] = int'(iss_rd); etwd[me][ms] = int'(iss_word); end
            else begin
                ev[fid] = 1; ef[fid] = 0; eline[fid] = int'(iss_line);
                etv[fid][0] = 1; etv[fid][1] = 0;
                etrd[fid][0] = int'(iss_rd); etwd[fid][0] = int'(iss_word);
            end
        end
        last_fire = fire;
    endtask

    task automatic step();
        #1 eval();
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic put(bit ld, bit hit, int rs1, int rs2, int rd, int line, int word);
        iss_valid = 1; iss_is_load = ld; iss_hit = hit; iss_rd_en = 1;
        iss_rs1 = 5'(rs1); iss_rs2 = 5'(rs2); iss_rd = 5'(rd);
        iss_line = 26'(line); iss_word = 2'(word); iss_hit_data = $urandom;
    endtask

    task automatic give_fill(int id);
        fill_valid = 1; fill_id = 2'(id);
        fill_data = {$urandom, $urandom, $urandom, $urandom};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        iss_valid = 0; iss_is_load = 0; iss_rd_en = 0; iss_hit = 0;
        iss_rs1 = 0; iss_rs2 = 0; iss_rd = 0; iss_line = 0; iss_word = 0; iss_hit_data = 0;
        fill_valid = 0; fill_id = 0; fill_data = '0;
        sk_v = 0;
        for (int r = 0; r < 32; r++) m_busy[r] = 0;
        for (int e = 0; e < 4; e++) begin ev[e] = 0; ef[e] = 0; etv[e][0] = 0; etv[e][1] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: idle after reset
        chk(!iss_stall && !miss_req_valid && !wb_valid, "R11", "idle outputs", {iss_stall, miss_req_valid, wb_valid}, 0);
        step();
        // directed opening
        put(1, 0, 0, 0, 1, 100, 1); step();            // R2 miss, entry 0
        put(1, 1, 0, 0, 2, 0, 0);   step();            // R1 hit under miss
        put(1, 0, 0, 0, 3, 100, 2); step();            // R4 merge
        put(1, 0, 0, 0, 4, 100, 3); step(); step();    // R10 join slots full
        put(0, 0, 1, 0, 9, 0, 0);   step();            // R5 reads busy r1
        put(1, 0, 0, 0, 5, 200, 0); step();            // entry 1
        put(1, 0, 0, 0, 6, 300, 0); step();            // entry 2
        put(1, 0, 0, 0, 7, 400, 0); step();            // entry 3
        put(1, 0, 0, 0, 8, 500, 0); step();            // R3 buffer full
        give_fill(2); step();                          // R8 out of order fill
        put(1, 1, 0, 0, 10, 0, 0); step();             // R9 hit meets fill write-back
        put(1, 1, 0, 0, 11, 0, 0); step();             // R9 skid occupied or draining
        step();
        put(1, 0, 0, 0, 8, 500, 0); step();            // R3 entry freed
        give_fill(0); step(); step(); step();          // R7, R4 merged write-backs
        put(0, 0, 3, 0, 12, 0, 0); step();             // R7 dependant
        // random phase
        for (int c = 0; c < 4000; c++) begin
            if (last_fire || !iss_valid) begin
                if ($urandom_range(0, 9) < 2) iss_valid = 0;
                else put($urandom_range(0, 9) < 6, $urandom_range(0, 1) == 1,
                         $urandom_range(0, 11), $urandom_range(0, 11), $urandom_range(0, 7),
                         $urandom_range(0, 5), $urandom_range(0, 3));
            end
            if ($urandom_range(0, 99) < 35) begin
                int pick, n;
                n = 0; pick = -1;
                for (int e = 0; e < 4; e++)
                    if (ev[e] && !ef[e]) begin
                        n++;
                        if ($urandom_range(1, n) == 1) pick = e;
                    end
                if (pick >= 0) give_fill(pick);
            end
            if (!iss_valid) last_fire = 1;
            step();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule